// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar date as seven packed-BCD registers: seconds, minutes, hours, date, month, day of week and a two-digit year. In each byte the upper nibble holds the tens digit and the lower nibble holds the units digit. A one-cycle `tick` pulse, normally produced once per second elsewhere on the chip, advances the count by one second. Carries ripple through the whole chain in the same cycle, so one tick can move the block from the last second of a year to the first second of the next.

The hours register runs in either 24-hour or 12-hour form, with an afternoon flag in 12-hour form. Month lengths are applied automatically, and February gets a 29th day in leap years. A host writes any register through a single strobe with a register index and a data byte. All seven values are available in parallel as registered outputs. Bit 7 of the seconds register is a halt flag that freezes the whole count.

Top module: `bcd_rtc_core`

## Requirements
- R1: After synchronous reset the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour form), date 0x01, month 0x01, day of week 0x01 and year 0x00.
- R2: Seconds advance by one BCD step on each clock edge where `tick` is 1 and the halt flag (seconds bit 7) is 0. Seconds 0x59 wrap to 0x00 and add one minute, and minutes 0x59 wrap to 0x00 and add one hour. With `tick` at 0 and no write, no register changes.
- R3: While seconds bit 7 is 1, ticks change no register. Writing bit 7 back to 0 lets counting resume from the stored value.
- R4: With hours bit 7 at 0 (24-hour form), bits 5:4 hold the tens of hours. Hour 0x23 wraps to 0x00 and advances the date and the day of week.
- R5: With hours bit 7 at 1 (12-hour form), bit 5 is the PM flag and bits 4:0 hold hours 01 to 12. 11 becomes 12 and flips the flag. 12 becomes 01 and keeps the flag. Leaving 11 PM gives 12 AM and advances the day. The form bit is kept while counting.
- R6: The last date is 0x30 for months 0x04, 0x06, 0x09 and 0x11, and 0x31 for every other month except 0x02. Passing the last date sets the date to 0x01 and advances the month.
- R7: February ends on 0x29 when the BCD year is divisible by 4 (including 0x00), and on 0x28 otherwise.
- R8: Day of week counts 1 to 7, and 7 wraps to 1 on a day carry.
- R9: Month 0x12 wraps to 0x01 and advances the year, and year 0x99 wraps to 0x00.
- R10: A write with `wr_en` at 1 loads `wr_data` into the register indexed by `wr_addr` (0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year) at the next edge. It wins over a tick increment of that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance enable, one cycle wide |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 8 | Write data byte |
| sec_q | output | 8 | Seconds (bit 7 halt flag) |
| min_q | output | 8 | Minutes |
| hour_q | output | 8 | Hours (bit 7 12-hour form, bit 5 PM) |
| date_q | output | 8 | Date of month |
| month_q | output | 8 | Month |
| dow_q | output | 8 | Day of week |
| year_q | output | 8 | Two-digit year |

## Verification
The hardest states to reach are the long carry chains. Examples are leaving the last second of February in a leap year, the last second of 11 PM in 12-hour form, and the last second of a century. Counting to these from reset would take millions of ticks. The bench therefore loads all seven registers through the host port with values one tick short of each boundary, then issues a single tick and compares the full seven-byte state against the value computed from the calendar rules. Writes that coincide with a tick, and ticks issued while the halt flag is set, are driven directly to check precedence and freezing.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_N  = 7;
  localparam int ADDR_W = $clog2(REG_N);

  typedef enum logic [ADDR_W-1:0] {
    RA_SEC   = 3'd0,
    RA_MIN   = 3'd1,
    RA_HOUR  = 3'd2,
    RA_DATE  = 3'd3,
    RA_MONTH = 3'd4,
    RA_DOW   = 3'd5,
    RA_YEAR  = 3'd6
  } reg_idx_e;

  // One packed-BCD step of a two-digit value.
  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    logic [3:0] lo;
    logic [3:0] hi;
    if (v[3:0] == 4'd9) begin
      lo = 4'd0;
      hi = v[7:4] + 4'd1;
    end else begin
      lo = v[3:0] + 4'd1;
      hi = v[7:4];
    end
    return {hi, lo};
  endfunction
endpackage

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap
  import rtc_pkg::*;
(
  input  logic [BYTE_W-1:0] cur,
  input  logic [BYTE_W-1:0] first,
  input  logic [BYTE_W-1:0] last,
  output logic [BYTE_W-1:0] nxt,
  output logic              at_last
);
  always_comb begin
    at_last = (cur == last);
    nxt     = at_last ? first : bcd_inc(cur);
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
  import rtc_pkg::*;
(
  input  logic [BYTE_W-1:0] cur,
  output logic [BYTE_W-1:0] nxt,
  output logic              day_carry
);
  logic       pm;
  logic [4:0] h12;

  always_comb begin
    pm        = cur[5];
    h12       = cur[4:0];
    nxt       = cur;
    day_carry = 1'b0;
    if (cur[7]) begin
      if (h12 == 5'h12) begin
        nxt = {2'b10, pm, 5'h01};
      end else if (h12 == 5'h11) begin
        nxt       = {2'b10, ~pm, 5'h12};
        day_carry = pm;
      end else begin
        nxt = {2'b10, pm, bcd_inc({3'b000, h12})[4:0]};
      end
    end else begin
      if (cur[5:0] == 6'h23) begin
        nxt       = 8'h00;
        day_carry = 1'b1;
      end else begin
        nxt = {2'b00, bcd_inc({2'b00, cur[5:0]})[5:0]};
      end
    end
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  logic [BYTE_W-1:0] month,
  input  logic [BYTE_W-1:0] year,
  output logic [BYTE_W-1:0] last_date
);
  logic leap;

  always_comb begin
    // Divisible by 4: even tens need units 0/4/8, odd tens need 2/6.
    if (year[4])
      leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
    else
      leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) || (year[3:0] == 4'd8);
    case (month)
      8'h02:                      last_date = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter logic [7:0] RST_DATE  = 8'h01,
  parameter logic [7:0] RST_MONTH = 8'h01,
  parameter logic [7:0] RST_DOW   = 8'h01,
  parameter logic [7:0] RST_YEAR  = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] date_q,
  output logic [7:0] month_q,
  output logic [7:0] dow_q,
  output logic [7:0] year_q
);
  logic [BYTE_W-1:0] regs_q [REG_N];
  logic [BYTE_W-1:0] step   [REG_N];
  logic [REG_N-1:0]  adv;
  logic [REG_N-1:0]  wrap;
  logic [BYTE_W-1:0] last_date;

  rtc_bcd_wrap u_sec (.cur(regs_q[RA_SEC]), .first(8'h00), .last(8'h59),
                      .nxt(step[RA_SEC]), .at_last(wrap[RA_SEC]));
  rtc_bcd_wrap u_min (.cur(regs_q[RA_MIN]), .first(8'h00), .last(8'h59),
                      .nxt(step[RA_MIN]), .at_last(wrap[RA_MIN]));
  rtc_hour_step u_hour (.cur(regs_q[RA_HOUR]), .nxt(step[RA_HOUR]),
                        .day_carry(wrap[RA_HOUR]));
  rtc_month_len u_mlen (.month(regs_q[RA_MONTH]), .year(regs_q[RA_YEAR]),
                        .last_date(last_date));
  rtc_bcd_wrap u_date (.cur(regs_q[RA_DATE]), .first(8'h01), .last(last_date),
                       .nxt(step[RA_DATE]), .at_last(wrap[RA_DATE]));
  rtc_bcd_wrap u_mon (.cur(regs_q[RA_MONTH]), .first(8'h01), .last(8'h12),
                      .nxt(step[RA_MONTH]), .at_last(wrap[RA_MONTH]));
  rtc_bcd_wrap u_dow (.cur(regs_q[RA_DOW]), .first(8'h01), .last(8'h07),
                      .nxt(step[RA_DOW]), .at_last(wrap[RA_DOW]));
  rtc_bcd_wrap u_year (.cur(regs_q[RA_YEAR]), .first(8'h00), .last(8'h99),
                       .nxt(step[RA_YEAR]), .at_last(wrap[RA_YEAR]));

  // Carry chain: every stage advances in the same cycle as the tick.
  always_comb begin
    adv[RA_SEC]   = tick & ~regs_q[RA_SEC][7];
    adv[RA_MIN]   = adv[RA_SEC] & wrap[RA_SEC];
    adv[RA_HOUR]  = adv[RA_MIN] & wrap[RA_MIN];
    adv[RA_DATE]  = adv[RA_HOUR] & wrap[RA_HOUR];
    adv[RA_DOW]   = adv[RA_DATE];
    adv[RA_MONTH] = adv[RA_DATE] & wrap[RA_DATE];
    adv[RA_YEAR]  = adv[RA_MONTH] & wrap[RA_MONTH];
  end

  function automatic logic [BYTE_W-1:0] rst_val(input int idx);
    case (idx)
      RA_DATE:  return RST_DATE;
      RA_MONTH: return RST_MONTH;
      RA_DOW:   return RST_DOW;
      RA_YEAR:  return RST_YEAR;
      default:  return 8'h00;
    endcase
  endfunction

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[g] <= rst_val(g);
      else if (wr_en && (wr_addr == ADDR_W'(g)))
        regs_q[g] <= wr_data;
      else if (adv[g])
        regs_q[g] <= step[g];
    end
  end

  assign sec_q   = regs_q[RA_SEC];
  assign min_q   = regs_q[RA_MIN];
  assign hour_q  = regs_q[RA_HOUR];
  assign date_q  = regs_q[RA_DATE];
  assign month_q = regs_q[RA_MONTH];
  assign dow_q   = regs_q[RA_DOW];
  assign year_q  = regs_q[RA_YEAR];
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hour_q,
  input logic [7:0] date_q,
  input logic [7:0] month_q,
  input logic [7:0] dow_q,
  input logic [7:0] year_q
);
  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd0) |=> (sec_q == $past(wr_data)));

  p_halt_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (sec_q[7] && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)));

  p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> ($stable(sec_q) && $stable(date_q) && $stable(year_q)));

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && sec_q == 8'h59) |=> (sec_q == 8'h00));

  p_dow_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && sec_q == 8'h59 && min_q == 8'h59 && hour_q == 8'h23
     && dow_q == 8'h07) |=> (dow_q == 8'h01));

  p_mode_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && hour_q[7]) |=> hour_q[7]);

  p_month_range_r9: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && month_q >= 8'h01 && month_q <= 8'h12)
      |=> (month_q >= 8'h01 && month_q <= 8'h12));
endmodule

bind bcd_rtc_core rtc_core_chk u_chk (.*);

// File: tb/bcd_rtc_core_tb.sv
`timescale 1ns/1ps
module bcd_rtc_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_q, min_q, hour_q, date_q, month_q, dow_q, year_q;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [55:0] vec;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  bcd_rtc_core u_dut (.*);

  function automatic logic [55:0] pk(input logic [7:0] s, m, h, d, mo, w, y);
    return {y, w, mo, d, h, m, s};
  endfunction

  // Monitor: compares one expected item per falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t e;
        logic [55:0] got;
        e = sb.pop_front();
        got = pk(sec_q, min_q, hour_q, date_q, month_q, dow_q, year_q);
        total++;
        if (got !== e.vec) begin
          bad++;
          $display("FAIL %s got=%h exp=%h", e.tag, got, e.vec);
        end
      end
    end
  end

  task automatic expect_now(input logic [55:0] v, input string tag);
    item_t e;
    e.vec = v;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic cyc(input logic t, input logic we, input logic [2:0] a,
                     input logic [7:0] d);
    @(negedge clk);
    tick = t; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic load(input logic [7:0] s, m, h, d, mo, w, y);
    cyc(0, 1, 3'd0, s); cyc(0, 1, 3'd1, m); cyc(0, 1, 3'd2, h);
    cyc(0, 1, 3'd3, d); cyc(0, 1, 3'd4, mo); cyc(0, 1, 3'd5, w);
    cyc(0, 1, 3'd6, y);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    cyc(0, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00), "R1 reset state");

    // R10 address map, R2 second stepping and minute carry
    load(8'h58, 8'h07, 8'h09, 8'h14, 8'h03, 8'h02, 8'h31);
    expect_now(pk(8'h58, 8'h07, 8'h09, 8'h14, 8'h03, 8'h02, 8'h31), "R10 load map");
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h59, 8'h07, 8'h09, 8'h14, 8'h03, 8'h02, 8'h31), "R2 sec step");
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h08, 8'h09, 8'h14, 8'h03, 8'h02, 8'h31), "R2 minute carry");
    cyc(0, 0, 3'd0, 8'h00);
    cyc(0, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h08, 8'h09, 8'h14, 8'h03, 8'h02, 8'h31), "R2 no tick idle");
    load(8'h59, 8'h59, 8'h09, 8'h14, 8'h03, 8'h02, 8'h31);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'h10, 8'h14, 8'h03, 8'h02, 8'h31), "R2 hour carry bcd");

    // R3 halt
    cyc(0, 1, 3'd0, 8'hB0);
    cyc(1, 0, 3'd0, 8'h00); cyc(1, 0, 3'd0, 8'h00); cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'hB0, 8'h00, 8'h10, 8'h14, 8'h03, 8'h02, 8'h31), "R3 halted");
    cyc(0, 1, 3'd0, 8'h30);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h31, 8'h00, 8'h10, 8'h14, 8'h03, 8'h02, 8'h31), "R3 resume");

    // R10 write beats tick
    cyc(1, 1, 3'd0, 8'h05);
    expect_now(pk(8'h05, 8'h00, 8'h10, 8'h14, 8'h03, 8'h02, 8'h31), "R10 write over tick");

    // R4 + R8 24-hour day rollover with weekday wrap
    load(8'h59, 8'h59, 8'h23, 8'h15, 8'h06, 8'h07, 8'h23);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'h00, 8'h16, 8'h06, 8'h01, 8'h23), "R4 R8 midnight");

    // R5 12-hour form
    load(8'h59, 8'h59, 8'h91, 8'h10, 8'h06, 8'h03, 8'h23);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'hB2, 8'h10, 8'h06, 8'h03, 8'h23), "R5 11AM to 12PM");
    load(8'h59, 8'h59, 8'hB2, 8'h10, 8'h06, 8'h03, 8'h23);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'hA1, 8'h10, 8'h06, 8'h03, 8'h23), "R5 12PM to 1PM");
    load(8'h59, 8'h59, 8'hB1, 8'h10, 8'h06, 8'h03, 8'h23);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'h92, 8'h11, 8'h06, 8'h04, 8'h23), "R5 11PM to 12AM");

    // R6 30/31-day months
    load(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h03, 8'h23);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h04, 8'h23), "R6 april end");
    load(8'h59, 8'h59, 8'h23, 8'h30, 8'h05, 8'h03, 8'h23);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'h00, 8'h31, 8'h05, 8'h04, 8'h23), "R6 may 31st");

    // R7 February
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03, 8'h24);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h04, 8'h24), "R7 leap 28 to 29");
    load(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h03, 8'h24);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h04, 8'h24), "R7 leap 29 end");
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03, 8'h23);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h04, 8'h23), "R7 common 28 end");
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03, 8'h00);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h04, 8'h00), "R7 year 00 leap");
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03, 8'h12);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h04, 8'h12), "R7 year 12 leap");
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03, 8'h10);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h04, 8'h10), "R7 year 10 common");

    // R9 year end
    load(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h07, 8'h29);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h30), "R9 new year bcd");
    load(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h05, 8'h99);
    cyc(1, 0, 3'd0, 8'h00);
    expect_now(pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h06, 8'h00), "R9 century wrap");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule